// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Fetch Sequencer

This block is the processor-side service controller for external interrupt requests that arrive on a byte-wide I/O bus. When an instruction completes and that instruction was not privileged, the block looks at the request line. If a device is asking, the block raises an acknowledge strobe toward the bus. It holds the strobe for a fixed span of clocks and latches a 6-bit vector from the input data lines at a programmed delay within that span. It then drops the strobe.

With the vector in hand, the block forms a byte address in the first memory page. The upper bits are fixed at `01` and the vector fills the next six bits. Through a request/valid memory read port, it reads two consecutive bytes from that address to build a 16-bit entry point. It then pulses a call strobe with that entry point toward the instruction sequencer. A busy flag stalls the instruction sequencer from the first acknowledge cycle through the call cycle.

Top module: `irq_vector_seq`

## Requirements
- R1: A request is accepted only in a cycle where `insn_end` and `irq_req` are both high and `insn_priv` is low. `iack` goes high in the following cycle. A boundary with `irq_req` low starts nothing.
- R2: When `insn_priv` is high at a boundary, the request is not taken. `iack` and `busy` stay low.
- R3: Once raised, `iack` stays high for exactly `ACK_HOLD_CYC` consecutive cycles, then falls.
- R4: The vector is `idata_in[5:0]`, sampled at the clock edge that ends the `ACK_CAPTURE_CYC`-th cycle of `iack` high. Values on `idata_in` before or after that edge have no effect on the fetched addresses.
- R5: Memory reads begin only after `iack` has fallen. The first read address is `{2'b01, vector, 1'b0}` and the second is `{2'b01, vector, 1'b1}` (9 bits). `mem_rd_addr` holds steady while `mem_rd_en` waits for `mem_rd_valid`.
- R6: One cycle after the second byte's `mem_rd_valid`, `call_stb` is high for exactly one cycle. `call_addr` is then {first byte, second byte}, with the first byte as the upper 8 bits.
- R7: `busy` is high from the first `iack` cycle through the `call_stb` cycle inclusive, and low in the cycle after.
- R8: Requests and boundaries seen while `busy` is high are ignored. After the call, a held-high `irq_req` is not taken again until a new `insn_end`.
- R9: After reset, `iack`, `busy`, `mem_rd_en` and `call_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | External interrupt request (active high) |
| insn_end | input | 1 | Current macro instruction completes this cycle |
| insn_priv | input | 1 | Completing instruction is privileged (I/O or jump) |
| idata_in | input | 8 | Input data lines; vector in bits 5:0 |
| iack | output | 1 | Interrupt acknowledge to the bus |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 9 | Memory byte address |
| mem_rd_data | input | 8 | Memory read byte |
| mem_rd_valid | input | 1 | Read byte valid this cycle |
| busy | output | 1 | Stall for the instruction sequencer |
| call_stb | output | 1 | One-cycle call strobe |
| call_addr | output | 16 | Entry address accompanying the call strobe |

## Verification
The bench builds the block with `ACK_CAPTURE_CYC` set to 3 and `ACK_HOLD_CYC` set to 6. These short windows allow every one of the 64 vectors to be served in full within a short run. The bench holds the data lines at a wrong value until the exact capture cycle. It also varies the memory latency from one to three cycles per vector. This exposes a capture that happens one cycle off, as well as read addresses and byte ordering that do not match the page-one arithmetic. Blocked cases are checked at the ports: privileged boundaries, requests without a boundary, and a request held after service.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [1:0] {
        TOP_IDLE  = 2'd0,
        TOP_ACK   = 2'd1,
        TOP_FETCH = 2'd2
    } top_state_e;

    typedef enum logic [1:0] {
        FET_IDLE = 2'd0,
        FET_HI   = 2'd1,
        FET_LO   = 2'd2,
        FET_DONE = 2'd3
    } fet_state_e;

    localparam logic [1:0] PAGE_BITS = 2'b01;

endpackage

// File: rtl/irqv_ack_timer.sv
module irqv_ack_timer #(
    parameter int CAP_CYC  = 38,
    parameter int HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ack,
    output logic cap_pulse,
    output logic done_pulse
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        cap_pulse  = r_q.active && (r_q.cnt == CW'(CAP_CYC - 1));
        done_pulse = r_q.active && (r_q.cnt == CW'(HOLD_CYC - 1));
        if (!r_q.active) begin
            if (start) begin
                r_d.active = 1'b1;
                r_d.cnt    = '0;
            end
        end else if (done_pulse) begin
            r_d.active = 1'b0;
            r_d.cnt    = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ack = r_q.active;

endmodule

// File: rtl/irqv_vec_fetch.sv
module irqv_vec_fetch
    import irqv_pkg::*;
#(
    parameter int VEC_W  = 6,
    parameter int DATA_W = 8,
    localparam int AW    = 2 + VEC_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VEC_W-1:0]    vec,
    output logic                rd_en,
    output logic [AW-1:0]       rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                rd_valid,
    output logic                done,
    output logic [2*DATA_W-1:0] entry
);
    typedef struct packed {
        fet_state_e        st;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } fet_t;

    fet_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        rd_en   = (r_q.st == FET_HI) || (r_q.st == FET_LO);
        rd_addr = {PAGE_BITS, vec, (r_q.st == FET_LO)};
        done    = (r_q.st == FET_DONE);
        entry   = {r_q.hi, r_q.lo};
        unique case (r_q.st)
            FET_IDLE: if (start) r_d.st = FET_HI;
            FET_HI: if (rd_valid) begin
                r_d.hi = rd_data;
                r_d.st = FET_LO;
            end
            FET_LO: if (rd_valid) begin
                r_d.lo = rd_data;
                r_d.st = FET_DONE;
            end
            FET_DONE: r_d.st = FET_IDLE;
            default:  r_d.st = FET_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= FET_IDLE;
            r_q.hi <= '0;
            r_q.lo <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
    import irqv_pkg::*;
#(
    parameter int ACK_CAPTURE_CYC = 38,
    parameter int ACK_HOLD_CYC    = 200,
    parameter int VEC_W           = 6,
    parameter int DATA_W          = 8,
    localparam int AW             = 2 + VEC_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_req,
    input  logic                insn_end,
    input  logic                insn_priv,
    input  logic [DATA_W-1:0]   idata_in,
    output logic                iack,
    output logic                mem_rd_en,
    output logic [AW-1:0]       mem_rd_addr,
    input  logic [DATA_W-1:0]   mem_rd_data,
    input  logic                mem_rd_valid,
    output logic                busy,
    output logic                call_stb,
    output logic [2*DATA_W-1:0] call_addr
);
    typedef struct packed {
        top_state_e       st;
        logic [VEC_W-1:0] vec;
    } top_t;

    top_t r_q, r_d;
    logic take, cap_pulse, ack_done, fet_done;

    irqv_ack_timer #(
        .CAP_CYC  (ACK_CAPTURE_CYC),
        .HOLD_CYC (ACK_HOLD_CYC)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (take),
        .ack        (iack),
        .cap_pulse  (cap_pulse),
        .done_pulse (ack_done)
    );

    irqv_vec_fetch #(
        .VEC_W  (VEC_W),
        .DATA_W (DATA_W)
    ) i_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ack_done),
        .vec      (r_q.vec),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .rd_data  (mem_rd_data),
        .rd_valid (mem_rd_valid),
        .done     (fet_done),
        .entry    (call_addr)
    );

    always_comb begin
        r_d  = r_q;
        take = 1'b0;
        unique case (r_q.st)
            TOP_IDLE: if (insn_end && irq_req && !insn_priv) begin
                take   = 1'b1;
                r_d.st = TOP_ACK;
            end
            TOP_ACK: begin
                if (cap_pulse) r_d.vec = idata_in[VEC_W-1:0];
                if (ack_done)  r_d.st  = TOP_FETCH;
            end
            TOP_FETCH: if (fet_done) r_d.st = TOP_IDLE;
            default: r_d.st = TOP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= TOP_IDLE;
            r_q.vec <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != TOP_IDLE);
    assign call_stb = fet_done;

endmodule

// File: rtl/irq_vector_seq_chk.sv
module irq_vector_seq_chk #(
    parameter int ACK_HOLD_CYC = 200,
    parameter int AW           = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_req,
    input logic          insn_end,
    input logic          insn_priv,
    input logic          iack,
    input logic          busy,
    input logic          mem_rd_en,
    input logic          mem_rd_valid,
    input logic [AW-1:0] mem_rd_addr,
    input logic          call_stb
);
    localparam int CW = $clog2(ACK_HOLD_CYC + 2);
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (iack) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_ACK_FROM_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack) |-> $past(insn_end && irq_req && !insn_priv)); // R1
    AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_end && insn_priv) |=> !iack); // R2
    AST_ACK_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iack) |-> (run_q == CW'(ACK_HOLD_CYC))); // R3
    AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iack |-> (run_q < CW'(ACK_HOLD_CYC))); // R3
    AST_READ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !iack); // R5
    AST_READ_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[AW-1:AW-2] == 2'b01)); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr))); // R5
    AST_CALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        call_stb |=> !call_stb); // R6
    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (iack || mem_rd_en || call_stb) |-> busy); // R7
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        call_stb |=> !busy); // R7
    AST_NO_RETAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !iack) |=> !$rose(iack)); // R8

endmodule

bind irq_vector_seq irq_vector_seq_chk #(
    .ACK_HOLD_CYC (ACK_HOLD_CYC),
    .AW           (AW)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req      (irq_req),
    .insn_end     (insn_end),
    .insn_priv    (insn_priv),
    .iack         (iack),
    .busy         (busy),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .call_stb     (call_stb)
);

// File: tb/test_irq_vector_seq.sv
module test_irq_vector_seq;
    localparam int CAP  = 3;
    localparam int HOLD = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, insn_end = 1'b0, insn_priv = 1'b0;
    logic [7:0]  idata_in = 8'hFF;
    logic        iack, mem_rd_en, busy, call_stb;
    logic [8:0]  mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] call_addr;

    int n_chk = 0, n_fail = 0;
    int mem_lat = 1, lat_cnt = 0, nrd = 0;
    logic [8:0] ra [2];
    bit finished = 0;

    always #4 clk = ~clk;

    irq_vector_seq #(.ACK_CAPTURE_CYC(CAP), .ACK_HOLD_CYC(HOLD)) i_irq_vector_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end),
        .insn_priv(insn_priv), .idata_in(idata_in), .iack(iack),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_rd_valid(mem_rd_valid), .busy(busy), .call_stb(call_stb),
        .call_addr(call_addr));

    function automatic logic [7:0] mem_byte(input logic [8:0] a);
        return 8'((a * 37 + 11) & 9'h0FF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model with programmable latency
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rd_valid = 1'b0;
            lat_cnt = 0;
        end else if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
        end else if (mem_rd_en) begin
            if (lat_cnt + 1 >= mem_lat) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_byte(mem_rd_addr);
                if (nrd < 2) ra[nrd] = mem_rd_addr;
                nrd++;
                lat_cnt = 0;
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic quiet(input int cycles, input string req);
        int rises = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (iack || busy) rises++;
        end
        check(rises == 0, req, rises, 0);
    endtask

    task automatic service(input logic [5:0] vec, input int lat);
        int k = 0, busy_bad = 0, ncall = 0;
        logic [15:0] got = '0;
        logic [8:0] a0 = {2'b01, vec, 1'b0};
        logic [8:0] a1 = {2'b01, vec, 1'b1};
        mem_lat = lat;
        nrd = 0;
        @(negedge clk);
        irq_req = 1'b1; insn_end = 1'b1; insn_priv = 1'b0;
        idata_in = {2'b11, ~vec};
        @(negedge clk);
        insn_end = 1'b0;
        check(iack == 1'b1, "R1 ack after boundary", iack, 1);
        for (int t = 0; t < 200; t++) begin
            if (t > 0) @(negedge clk);
            if (!busy) busy_bad++;
            if (iack) begin
                if (k == CAP - 1) idata_in = {2'b00, vec};
                else idata_in = {2'b10, ~vec};
                if (k == 1) insn_end = 1'b1;   // boundary during service: R8
                else insn_end = 1'b0;
                k++;
            end else begin
                idata_in = {2'b01, ~vec};
            end
            if (call_stb) begin
                ncall++;
                got = call_addr;
                break;
            end
        end
        insn_end = 1'b0;
        check(k == HOLD, "R3 ack span", k, HOLD);
        check(busy_bad == 0, "R7 busy during service", busy_bad, 0);
        check(nrd == 2 && ra[0] == a0, "R4/R5 first read address", ra[0], a0);
        check(ra[1] == a1, "R5 second read address", ra[1], a1);
        check(ncall == 1 && got == {mem_byte(a0), mem_byte(a1)}, "R6 entry address",
              got, {mem_byte(a0), mem_byte(a1)});
        @(negedge clk);
        check(!call_stb && !busy, "R6/R7 strobe and busy drop", {call_stb, busy}, 0);
        // request still held, no new boundary
        quiet(8, "R8 no retake without boundary");
        irq_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!iack && !busy && !mem_rd_en && !call_stb, "R9 reset state",
              {iack, busy, mem_rd_en, call_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // boundary without request
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        quiet(6, "R1 boundary without request");
        // request without boundary
        irq_req = 1'b1;
        quiet(10, "R1 request without boundary");
        // privileged boundary
        insn_end = 1'b1; insn_priv = 1'b1;
        @(negedge clk);
        insn_end = 1'b0; insn_priv = 1'b0;
        quiet(10, "R2 privileged boundary");
        irq_req = 1'b0;
        for (int v = 0; v < 64; v++) service(6'(v), (v % 3) + 1);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule